// File: doc/BRIEF.md
# Boundary Scan Register With Mixed Cell Kinds

This block is the chain of boundary-scan cells that sits between a chip's core logic and its pins. Every cell has two flops: a capture/shift stage that either loads a parallel value or passes serial data one position along the chain, and an update/hold stage that latches the capture stage on command. When the test mode is active, the hold stage drives the pins. In normal operation the core drives them directly.

The chain mixes cell kinds. A parameter array gives each position a kind, a pin and, for data cells, the control cell that gates its driver. The kinds are input cells, 2-state output cells, 3-state data cells, shared data cells for 2-cell bidirectional pins, and control cells. A 3-cell bidirectional pin is a 3-state data cell plus an input cell on the same pin. One control cell may gate several drivers. The test access controller supplies the data-register strobes, a mode select, a bypass select and a high-impedance force. For sample/preload it leaves the mode low. For external test it raises the mode. For clamp it raises both the mode and the bypass select. For high-impedance it raises the mode, the bypass select and the force.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, every capture flop, every hold flop and the bypass flop are 0, so `scan_out` reads 0.
- R2: On a clock edge with `clock_dr` and `shift_dr` high and `bypass_sel` low, `scan_in` enters cell 0 and each cell k takes the old value of cell k-1. `scan_out` shows the last cell (index NCELLS-1).
- R3: On a clock edge with `clock_dr` high, `shift_dr` low and `bypass_sel` low, each cell loads its parallel input. For an input cell and a shared bidirectional data cell, this is `pin_in` of its pin. For a 2-state or 3-state data cell, it is `core_out` of its pin. For a control cell, it is `core_oe` of its pin. The default chain is: 0 input on pin 0; 1 2-state on pin 1; 2 control on pin 2; 3 3-state on pin 2 gated by 2; 4 3-state on pin 3 gated by 2; 5 control on pin 4; 6 shared bidirectional on pin 4 gated by 5; 7 control on pin 5; 8 3-state on pin 5 gated by 7; 9 input on pin 5.
- R4: The hold stage copies the capture stage only on a clock edge with `update_dr` high and `bypass_sel` low. While a shift is in progress, the pins keep their values.
- R5: With `mode` low, each driven pin has `pin_out` equal to `core_out`. Its `pin_oe` equals `core_oe` for 3-state and bidirectional pins and is always 1 for 2-state pins, whatever the register holds.
- R6: With `mode` high, each driven pin takes `pin_out` from its data cell's hold stage. Its `pin_oe` comes from the hold stage of its control cell, where 1 enables the driver. One control cell gates every pin that names it. A 2-state pin always drives.
- R7: With `bypass_sel` high, the serial path is a 1-bit bypass flop. It loads 0 on a capture edge and `scan_in` on a shift edge, and `scan_out` shows it. The capture and hold stages do not change, so the pins keep the values held before.
- R8: With `highz` high, every `pin_oe` is 0.
- R9: The input cell of a 3-cell bidirectional pin captures the pin value, not the value the core is driving.
- R10: A pin with no driving cell (pin 0 in the default chain) has `pin_out` and `pin_oe` at 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous test reset, active low |
| shift_dr | input | 1 | Selects serial shift rather than parallel load |
| clock_dr | input | 1 | Enables the capture/shift stage (or the bypass flop) |
| update_dr | input | 1 | Loads the hold stage from the capture stage |
| mode | input | 1 | 1 = pins driven from the hold stage |
| bypass_sel | input | 1 | 1 = serial path through the 1-bit bypass flop |
| highz | input | 1 | 1 = all output drivers disabled |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out |
| core_out | input | NPINS | Data the core drives toward each pin |
| core_oe | input | NPINS | Driver enables from the core |
| pin_in | input | NPINS | Values seen at the pins |
| pin_out | output | NPINS | Data toward the pin drivers |
| pin_oe | output | NPINS | Pin driver enables |

## Verification
The bench shifts known vectors through the chain. A scoreboard compares every bit that leaves `scan_out` with the value the cell kind should have captured. A wrong source in a control or bidirectional cell, such as a 3-cell input cell that captures core data, would put a wrong bit at a predictable shift position. During each shift the bench samples the pins. A hold stage that follows the capture stage would make them flicker during external test. After sample/preload and clamp scans it checks that the pins do not move, since a register that clocks while bypassed would replace the clamped values. It drives two vectors with opposite control bits to confirm that one shared control cell gates both its pins together, that the force disables every driver, and that the undriven pin stays at 0.

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain #(
  parameter int NCELLS = 10,
  parameter int NPINS  = 6,
  parameter int CELL_KIND [NCELLS] = '{0, 1, 4, 2, 2, 4, 3, 4, 2, 0},
  parameter int CELL_PIN  [NCELLS] = '{0, 1, 2, 2, 3, 4, 4, 5, 5, 5},
  parameter int CELL_CTL  [NCELLS] = '{0, 0, 0, 2, 2, 0, 5, 0, 7, 0}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_dr,
  input  logic             clock_dr,
  input  logic             update_dr,
  input  logic             mode,
  input  logic             bypass_sel,
  input  logic             highz,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int K_IN   = 0;
  localparam int K_OUT2 = 1;
  localparam int K_OUT3 = 2;
  localparam int K_BIDI = 3;
  localparam int K_CTL  = 4;

  logic [NCELLS-1:0] cap, upd, par;
  logic              byp;

  always_comb begin
    for (int i = 0; i < NCELLS; i++) begin
      case (CELL_KIND[i])
        K_IN, K_BIDI: par[i] = pin_in[CELL_PIN[i]];
        K_CTL:        par[i] = core_oe[CELL_PIN[i]];
        default:      par[i] = core_out[CELL_PIN[i]];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cap <= '0;
    else if (clock_dr && !bypass_sel) cap <= shift_dr ? {cap[NCELLS-2:0], scan_in} : par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        upd <= '0;
    else if (update_dr && !bypass_sel) upd <= cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      byp <= 1'b0;
    else if (clock_dr && bypass_sel) byp <= shift_dr & scan_in;
  end

  assign scan_out = bypass_sel ? byp : cap[NCELLS-1];

  always_comb begin
    pin_out = '0;
    pin_oe  = '0;
    for (int i = 0; i < NCELLS; i++) begin
      if (CELL_KIND[i] == K_OUT2 || CELL_KIND[i] == K_OUT3 || CELL_KIND[i] == K_BIDI) begin
        pin_out[CELL_PIN[i]] = mode ? upd[i] : core_out[CELL_PIN[i]];
        if (highz)                     pin_oe[CELL_PIN[i]] = 1'b0;
        else if (CELL_KIND[i] == K_OUT2) pin_oe[CELL_PIN[i]] = 1'b1;
        else                           pin_oe[CELL_PIN[i]] = mode ? upd[CELL_CTL[i]] : core_oe[CELL_PIN[i]];
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (scan_out == 1'b0 || !rst_n)) else $error("R1 chain not clear after reset");

  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clock_dr && shift_dr && !bypass_sel) |=> cap[0] == $past(scan_in))
    else $error("R2 scan_in not shifted into first cell");

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !update_dr |=> $stable(upd)) else $error("R4 hold stage moved without update");

  assert_pins_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !update_dr) |=> (!mode || $stable(pin_out)))
    else $error("R4 pin data moved in test mode without update");

  assert_bypass_isolates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_sel |=> ($stable(cap) && $stable(upd)))
    else $error("R7 boundary register touched while bypassed");

  assert_bypass_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clock_dr && !shift_dr && bypass_sel) |=> !byp)
    else $error("R7 bypass flop did not capture 0");

  assert_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    highz |-> pin_oe == '0) else $error("R8 driver enabled under highz");
endmodule

// File: tb/bscan_chain_bench.sv
`timescale 1ns/1ps
module bscan_chain_bench;
  localparam int N = 10;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n, shift_dr, clock_dr, update_dr, mode, bypass_sel, highz, scan_in, scan_out;
  logic [P-1:0] core_out, core_oe, pin_in, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bscan_chain u_bscan_chain (
    .clk(clk), .rst_n(rst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
    .update_dr(update_dr), .mode(mode), .bypass_sel(bypass_sel), .highz(highz),
    .scan_in(scan_in), .scan_out(scan_out), .core_out(core_out), .core_oe(core_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(string req, logic [P-1:0] act, logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && shift_dr && clock_dr) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected shift, actual %b expected none", scan_out);
      end else begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (scan_out !== e) begin
          fails++;
          $display("FAIL %s scan_out actual %b expected %b", t, scan_out, e);
        end
      end
    end
  end

  function automatic logic [N-1:0] exp_cap(logic [P-1:0] pi, logic [P-1:0] co, logic [P-1:0] oe);
    return {pi[5], co[5], oe[5], pi[4], oe[4], co[3], co[2], oe[2], co[1], pi[0]};
  endfunction

  function automatic logic [2*P-1:0] test_pins(logic [N-1:0] v);
    logic [P-1:0] o, e;
    o = {v[8], v[6], v[4], v[3], v[1], 1'b0};
    e = {v[7], v[5], v[2], v[2], 1'b1, 1'b0};
    return {o, e};
  endfunction

  function automatic logic [2*P-1:0] func_pins(logic [P-1:0] co, logic [P-1:0] oe);
    return {co & 6'b111110, oe[5:2], 2'b10};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic dr_scan(logic [N-1:0] v, logic [N-1:0] cap_exp, logic [2*P-1:0] mid, string req);
    clock_dr = 1'b1; shift_dr = 1'b0;
    step();
    shift_dr = 1'b1;
    for (int k = 0; k < N; k++) begin
      scan_in = v[N-1-k];
      if (bypass_sel) begin
        exp_q.push_back(k == 0 ? 1'b0 : v[N-k]);
        tag_q.push_back("R7");
      end else begin
        exp_q.push_back(cap_exp[N-1-k]);
        tag_q.push_back((N-1-k) == 9 ? "R9" : "R3");
      end
      if (k == 5) begin
        @(negedge clk);
        check({req, " pins during shift"}, pin_out, mid[2*P-1:P]);
        check({req, " enables during shift"}, pin_oe, mid[P-1:0]);
      end
      step();
    end
    shift_dr = 1'b0; clock_dr = 1'b0; update_dr = 1'b1;
    step();
    update_dr = 1'b0;
  endtask

  task automatic pins_now(string req, logic [2*P-1:0] e);
    @(negedge clk);
    check({req, " pin_out"}, pin_out, e[2*P-1:P]);
    check({req, " pin_oe"}, pin_oe, e[P-1:0]);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL R1 watchdog expired, actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [N-1:0] v1, v2, v3;
    v1 = 10'h1D6;
    v2 = 10'h269;
    v3 = 10'h335;
    rst_n = 1'b0; shift_dr = 0; clock_dr = 0; update_dr = 0; mode = 0;
    bypass_sel = 0; highz = 0; scan_in = 0;
    core_out = 6'b101010; core_oe = 6'b110100; pin_in = 6'b011001;
    repeat (3) step();
    @(negedge clk);
    check("R1 scan_out in reset", {5'b0, scan_out}, 6'b0);
    pins_now("R5 reset functional", func_pins(core_out, core_oe));
    step();
    rst_n = 1'b1;
    step();

    dr_scan(v1, exp_cap(pin_in, core_out, core_oe), func_pins(core_out, core_oe), "R5 sample");
    pins_now("R5 after preload", func_pins(core_out, core_oe));
    core_out = 6'b010101; core_oe = 6'b001100;
    pins_now("R5 core change", func_pins(core_out, core_oe));

    mode = 1'b1;
    pins_now("R6 extest v1", test_pins(v1));
    pins_now("R10 undriven pin", test_pins(v1) & 12'b111110_111110);
    pin_in = 6'b100110;
    dr_scan(v2, exp_cap(pin_in, core_out, core_oe), test_pins(v1), "R4 extest");
    pins_now("R6 extest v2", test_pins(v2));

    bypass_sel = 1'b1;
    dr_scan(v3, '0, test_pins(v2), "R7 clamp");
    pins_now("R7 clamp hold", test_pins(v2));

    highz = 1'b1;
    pins_now("R8 highz", {test_pins(v2)} & 12'b111111_000000);

    highz = 1'b0; bypass_sel = 1'b0; mode = 1'b0;
    pins_now("R5 back to functional", func_pins(core_out, core_oe));

    summary();
    $finish;
  end
endmodule